// File: doc/BRIEF.md
# Message Channel Filter and Status

This block is one message channel of a serial-bus frame controller. When a frame ends on the bus, the channel checks whether the frame belongs to it. It compares the frame's 12-bit identifier with a programmed identifier, and a per-bit mask decides which bits take part. It also checks the data byte count against a 5-bit length code. An accepted frame raises a one-cycle match pulse, so that the surrounding controller knows to store the data.

The channel keeps three status bits: received, transmitted and error. These bits also act as host commands. The host arms a reception or a transmission by clearing the matching bit. Writing 1 to the error bit requests an abort of the programmed transmission. The hardware only sets the received and transmitted bits, and it does so only after an error-free frame or when the retries run out.

Host access is a byte-wide register port. Writes are registered and reads are combinational. Register addresses: 0 is status, 1 is the length code, 2 is identifier high, 3 is identifier low, 4 is mask high and 5 is mask low. Any other address reads zero.

Top module: `msg_channel`

## Requirements
- R1: The mask is 12 bits wide and sits in two registers. Address 4 holds mask[11:4]. Address 5 holds mask[3:0] in data bits 7:4, and its bits 3:0 always read 0. The identifier uses the same layout at addresses 2 (high) and 3 (low).
- R2: A received frame matches only if `((frame_id ^ ident) & mask) == 0`. A mask bit of 0 removes that identifier bit from the compare.
- R3: Length code n in the range 1..31 expects n-1 data bytes. If an identifier-matching frame arrives on an armed channel with a different byte count, the error bit (status bit 2) is set and the received bit is not.
- R4: Length code 0 marks a linked channel. Received frames then set no status bit and raise no match pulse.
- R5: A received frame with no error, a matching identifier, a correct length and the received bit (status bit 0) at 0 sets the received bit. It also raises `match` for exactly one cycle, in the cycle after the end-of-frame strobe. When the received bit is 1, frames are ignored.
- R6: The transmitted bit (status bit 1) is set by an error-free end of a transmitted frame, or by the retry-exhausted strobe.
- R7: The error strobe sets the error bit for a transmitted frame, or for a matching frame on an armed channel. When the error strobe and the end-of-frame strobe come in the same cycle, neither the received bit nor the transmitted bit is set. A host write of 0 to bit 2 clears the error bit.
- R8: A host write to status can only clear the received and transmitted bits: a 0 clears the bit and a 1 leaves it unchanged.
- R9: A host write with status bit 2 at 1 sets the error bit and raises `abort_req` for exactly one cycle.
- R10: When a hardware set and a host clear hit the same status bit in the same cycle, the bit ends at 1.
- R11: After reset, status reads 0x00, the mask reads 0xFF at address 4 and 0xF0 at address 5, and `match` and `abort_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| frame_id | input | 12 | Decoded identifier of the current frame |
| frame_nbytes | input | 5 | Data byte count of the current frame |
| frame_is_tx | input | 1 | Current frame is this channel's transmission |
| frame_eof | input | 1 | End-of-frame strobe |
| frame_err | input | 1 | Frame error strobe |
| retry_out | input | 1 | Retry count exceeded strobe |
| match | output | 1 | One-cycle pulse for each accepted received frame |
| abort_req | output | 1 | One-cycle pulse on a host abort request |

## Verification
The assertions assume that the frame strobes last one cycle and that the identifier, the byte count and the direction are stable while a strobe is high. They also assume that no strobe is active during reset. The bench drives every strobe for exactly one cycle, starting from a falling clock edge, and returns all inputs to zero afterwards. Same-cycle overlaps are created only where a requirement concerns them: error together with end of frame, and a host clear together with a hardware set.

// File: rtl/msg_channel.sv
module msg_channel #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [2:0]       host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic [11:0]      frame_id,
  input  logic [LEN_W-1:0] frame_nbytes,
  input  logic             frame_is_tx,
  input  logic             frame_eof,
  input  logic             frame_err,
  input  logic             retry_out,
  output logic             match,
  output logic             abort_req
);
  localparam logic [2:0] A_STAT = 3'd0, A_LEN = 3'd1, A_IDH = 3'd2,
                         A_IDL = 3'd3, A_MSKH = 3'd4, A_MSKL = 3'd5;

  logic [11:0]      ident, mask;
  logic [LEN_W-1:0] len_code;
  logic             st_rx, st_tx, st_err;

  wire wr_stat  = host_wr && host_addr == A_STAT;
  wire id_hit   = ((frame_id ^ ident) & mask) == 12'd0;
  wire linked   = len_code == '0;
  wire len_ok   = frame_nbytes == LEN_W'(len_code - 1'b1);
  wire rx_cand  = !frame_is_tx && id_hit && !st_rx && !linked;

  wire accept   = frame_eof && !frame_err && rx_cand && len_ok;
  wire len_bad  = frame_eof && rx_cand && !len_ok;
  wire set_rx   = accept;
  wire set_tx   = (frame_eof && !frame_err && frame_is_tx) || retry_out;
  wire set_err  = (frame_err && (frame_is_tx || rx_cand)) || len_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ident    <= '0;
      mask     <= '1;
      len_code <= '0;
    end else if (host_wr) begin
      case (host_addr)
        A_LEN:  len_code    <= host_wdata[LEN_W-1:0];
        A_IDH:  ident[11:4] <= host_wdata;
        A_IDL:  ident[3:0]  <= host_wdata[7:4];
        A_MSKH: mask[11:4]  <= host_wdata;
        A_MSKL: mask[3:0]   <= host_wdata[7:4];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_rx     <= 1'b0;
      st_tx     <= 1'b0;
      st_err    <= 1'b0;
      match     <= 1'b0;
      abort_req <= 1'b0;
    end else begin
      st_rx     <= set_rx  | (st_rx  & ~(wr_stat & ~host_wdata[0]));
      st_tx     <= set_tx  | (st_tx  & ~(wr_stat & ~host_wdata[1]));
      st_err    <= set_err | (wr_stat ? host_wdata[2] : st_err);
      match     <= accept;
      abort_req <= wr_stat && host_wdata[2];
    end
  end

  always_comb begin
    case (host_addr)
      A_STAT:  host_rdata = {5'd0, st_err, st_tx, st_rx};
      A_LEN:   host_rdata = 8'(len_code);
      A_IDH:   host_rdata = ident[11:4];
      A_IDL:   host_rdata = {ident[3:0], 4'd0};
      A_MSKH:  host_rdata = mask[11:4];
      A_MSKL:  host_rdata = {mask[3:0], 4'd0};
      default: host_rdata = 8'd0;
    endcase
  end

  assert_mask_low_nibble_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr == A_MSKL |-> host_rdata[3:0] == 4'd0);

  assert_match_with_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> st_rx);

  assert_match_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !match || $past(frame_eof));

  assert_rx_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_rx) |-> $past(frame_eof && !frame_err && !frame_is_tx));

  assert_tx_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_tx) |-> $past((frame_eof && !frame_err && frame_is_tx) || retry_out));

  assert_err_clear_by_host_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_err) |-> $past(host_wr && host_addr == A_STAT && !host_wdata[2]));

  assert_abort_sets_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> st_err);
endmodule

// File: tb/msg_channel_bench.sv
module msg_channel_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [2:0] host_addr = 3'd0;
  logic [7:0] host_wdata = 8'd0, host_rdata;
  logic [11:0] frame_id = 12'd0;
  logic [4:0] frame_nbytes = 5'd0;
  logic frame_is_tx = 1'b0, frame_eof = 1'b0, frame_err = 1'b0, retry_out = 1'b0;
  logic match, abort_req;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  msg_channel u_msg_channel (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0; host_wdata = 8'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; #1 d = host_rdata;
  endtask

  task automatic frame(input logic [11:0] id, input logic [4:0] n, input logic tx,
                       input logic eof, input logic err, input logic rty, output logic m);
    @(negedge clk);
    frame_id = id; frame_nbytes = n; frame_is_tx = tx;
    frame_eof = eof; frame_err = err; retry_out = rty;
    @(negedge clk);
    m = match;
    frame_eof = 1'b0; frame_err = 1'b0; retry_out = 1'b0; frame_is_tx = 1'b0;
  endtask

  task automatic stat_is(input string req, input int exp);
    logic [7:0] d;
    rd(3'd0, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    stat_is("R11 status", 8'h00);
    rd(3'd4, d); chk("R11 mask hi", d, 8'hFF);
    rd(3'd5, d); chk("R11 mask lo", d, 8'hF0);
    chk("R11 match", match, 0);
    chk("R11 abort", abort_req, 0);
  endtask

  task automatic t_exact;
    logic m;
    wr(3'd2, 8'hA5); wr(3'd3, 8'hC0); wr(3'd1, 8'd5);
    frame(12'hA5C, 5'd4, 0, 1, 0, 0, m);
    chk("R5 match pulse", m, 1);
    @(negedge clk); chk("R5 match single", match, 0);
    stat_is("R5 rx set", 8'h01);
    frame(12'hA5C, 5'd4, 0, 1, 0, 0, m);
    chk("R5 not armed", m, 0);
    stat_is("R5 status kept", 8'h01);
    wr(3'd0, 8'h00); stat_is("R8 clear rx", 8'h00);
    wr(3'd0, 8'h03); stat_is("R8 write one no set", 8'h00);
  endtask

  task automatic t_mask;
    logic m; logic [7:0] d;
    frame(12'hA5D, 5'd4, 0, 1, 0, 0, m);
    chk("R2 mismatch", m, 0);
    stat_is("R2 mismatch status", 8'h00);
    wr(3'd5, 8'h0F);
    rd(3'd5, d); chk("R1 mask lo read", d, 8'h00);
    frame(12'hA53, 5'd4, 0, 1, 0, 0, m);
    chk("R2 masked match", m, 1);
    wr(3'd0, 8'h00);
    frame(12'hB5C, 5'd4, 0, 1, 0, 0, m);
    chk("R2 upper bit compared", m, 0);
    wr(3'd5, 8'hFF);
    rd(3'd5, d); chk("R1 mask lo nibble zero", d, 8'hF0);
  endtask

  task automatic t_length;
    logic m;
    frame(12'hA5C, 5'd3, 0, 1, 0, 0, m);
    chk("R3 bad length no match", m, 0);
    stat_is("R3 bad length err", 8'h04);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'd1);
    frame(12'hA5C, 5'd0, 0, 1, 0, 0, m);
    chk("R3 code1 zero bytes", m, 1);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'd31);
    frame(12'hA5C, 5'd30, 0, 1, 0, 0, m);
    chk("R3 code31 thirty bytes", m, 1);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'd0);
    frame(12'hA5C, 5'd31, 0, 1, 0, 0, m);
    chk("R4 linked no match", m, 0);
    frame(12'hA5C, 5'd0, 0, 1, 0, 0, m);
    stat_is("R4 linked status", 8'h00);
    wr(3'd1, 8'd5);
  endtask

  task automatic t_tx;
    logic m;
    frame(12'h000, 5'd0, 1, 1, 0, 0, m);
    stat_is("R6 tx done", 8'h02);
    wr(3'd0, 8'h00);
    frame(12'h000, 5'd0, 0, 0, 0, 1, m);
    stat_is("R6 retry exhausted", 8'h02);
    wr(3'd0, 8'h00);
    frame(12'h000, 5'd0, 1, 1, 1, 0, m);
    stat_is("R7 error over eof tx", 8'h04);
    wr(3'd0, 8'h00);
    frame(12'hA5C, 5'd4, 0, 1, 1, 0, m);
    chk("R7 error over eof rx match", m, 0);
    stat_is("R7 error over eof rx", 8'h04);
    wr(3'd0, 8'h00);
    stat_is("R7 host clears err", 8'h00);
  endtask

  task automatic t_collide;
    @(negedge clk);
    host_wr = 1'b1; host_addr = 3'd0; host_wdata = 8'h00;
    frame_is_tx = 1'b1; frame_err = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; frame_is_tx = 1'b0; frame_err = 1'b0;
    stat_is("R10 hw set wins", 8'h04);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_abort;
    @(negedge clk); host_wr = 1'b1; host_addr = 3'd0; host_wdata = 8'h04;
    @(negedge clk); host_wr = 1'b0;
    chk("R9 abort pulse", abort_req, 1);
    stat_is("R9 err set", 8'h04);
    chk("R9 abort one cycle", abort_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_exact; t_mask; t_length; t_tx; t_collide; t_abort;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule